// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block sequences a processor core through its power states and gates the core clock. It follows five states: Normal, AutoHALT, Stop-Grant, Grant-Snoop and Sleep. A halt request moves the core from Normal into AutoHALT. A stop-clock request, made from Normal or from AutoHALT, starts a handshake. The block raises a request for an acknowledge bus cycle. Once the system reports that the response phase of that cycle is complete, the block waits a fixed number of bus clocks and then enters Stop-Grant. Bus snoops and bus interrupts seen in AutoHALT or Stop-Grant move the block into Grant-Snoop for a short time. It then goes back to the low-power state it came from.

Sleep can be reached only from Stop-Grant, and all core clocks are off there. The block checks that the stop-clock request is held for a minimum number of clocks after Sleep ends. Events arriving while the core clock is stopped (init, system-management interrupt, two local interrupt lines, bus interrupt) are captured at most once each. They are replayed as single-clock pulses once the core is back in Normal. A break-event output tells the system that something is pending while the core is in Stop-Grant.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After `arst_n` the state is Normal and `core_clk_en_o` is 1. `ack_req_o`, `pbe_o`, `core_init_o`, `replay_o`, `proto_err_o` and `slp_err_o` are all 0. `state_o` encodes the states as 0 Normal, 1 AutoHALT, 2 Stop-Grant, 3 Grant-Snoop and 4 Sleep.
- R2: In Normal, `halt_n` low moves the state to AutoHALT on the next edge. In AutoHALT, `halt_n` high returns the state to Normal.
- R3: In Normal or AutoHALT, `stpclk_n` low raises `ack_req_o` until `ack_done_i` is sampled high. The state becomes Stop-Grant on the 20th edge after that sample. If `stpclk_n` rises before then, the sequence is abandoned and `ack_req_o` drops.
- R4: In Stop-Grant, `stpclk_n` high returns the state to the state that Stop-Grant was entered from (Normal or AutoHALT).
- R5: `snoop_i` or `bus_int_i` in AutoHALT or Stop-Grant moves the state to Grant-Snoop. The state then returns to the state it came from. For a snoop this happens on `snoop_done_i`. For a bus interrupt alone it happens one clock later, once the interrupt is captured.
- R6: `slp_n` low in Stop-Grant enters Sleep, and `slp_n` high in Sleep returns to Stop-Grant. Sleep is never entered from any other state. `core_clk_en_o` is 1 only in Normal.
- R7: After Sleep ends, `stpclk_n` high on any of the first 9 edges sets the sticky `proto_err_o`. `stpclk_n` high on the same edge that leaves Sleep also sets it. Rising on the 10th edge or later is legal.
- R8: `slp_n` low in Normal, AutoHALT or Grant-Snoop does not change the state, and it sets the sticky `slp_err_o`.
- R9: A falling edge on `cpu_rst_n` gives a one-clock `core_init_o` pulse and clears all captured events. In Normal or AutoHALT the state becomes Normal. In Stop-Grant the state stays Stop-Grant, and a later `stpclk_n` rise returns the state to Normal.
- R10: Init, SMI, local interrupt 0, local interrupt 1 and bus interrupt are each captured in a flag, however many times they arrive. In Normal they are replayed one per clock on `replay_o`, using bits 0 to 4 in that order of priority. Each replay clears its flag.
- R11: The bus interrupt is replayed only while `intr_en_i` is 1, and otherwise stays pending. In Stop-Grant, `pbe_o` is 1 whenever any event is captured, whatever the value of `intr_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| arst_n | input | 1 | Asynchronous block reset, active low |
| stpclk_n | input | 1 | Stop-clock request, active low |
| slp_n | input | 1 | Sleep request, active low |
| cpu_rst_n | input | 1 | Core reset request, active low |
| halt_n | input | 1 | Halt-instruction indication, active low |
| snoop_i | input | 1 | Bus snoop strobe |
| bus_int_i | input | 1 | Bus interrupt strobe |
| snoop_done_i | input | 1 | Snoop serviced |
| ack_done_i | input | 1 | Response phase of acknowledge cycle complete |
| smi_i | input | 1 | System-management interrupt strobe |
| init_i | input | 1 | Init strobe |
| lint_i | input | 2 | Local interrupt strobes |
| intr_en_i | input | 1 | Core interrupt-enable flag |
| state_o | output | 3 | Current power state |
| core_clk_en_o | output | 1 | Core clock enable |
| ack_req_o | output | 1 | Request for the acknowledge bus cycle |
| pbe_o | output | 1 | Pending break event |
| core_init_o | output | 1 | Core initialise pulse |
| replay_o | output | 5 | Replay pulses: init, SMI, lint0, lint1, bus interrupt |
| proto_err_o | output | 1 | Sticky Sleep-exit timing violation |
| slp_err_o | output | 1 | Sticky illegal sleep request |

## Verification
The bench goes after both edges of each counted window. It checks Stop-Grant on exactly the 20th edge and not the 19th, so a counter that is off by one moves the state a clock early or late. It checks that a stop-clock rise on the 10th edge after Sleep is accepted and that one on the 3rd edge is flagged. Returns from Stop-Grant and from Grant-Snoop are checked for both possible origin states, so a controller that always falls back to Normal shows up in the state it reports. For captured events, the bench delivers SMI twice and expects one replay, holds back a masked bus interrupt while the break event is still raised, and expects a core reset to wipe pending events and force a later return to Normal.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  typedef enum logic [2:0] {
    PS_RUN   = 3'd0,
    PS_HALT  = 3'd1,
    PS_GRANT = 3'd2,
    PS_SNOOP = 3'd3,
    PS_SLEEP = 3'd4
  } pstate_e;

  typedef enum logic [1:0] {
    EQ_IDLE = 2'd0,
    EQ_REQ  = 2'd1,
    EQ_WAIT = 2'd2
  } entry_ph_e;

  localparam int NEV = 5;

  // lowest-index set bit wins
  function automatic logic [NEV-1:0] pick_first(input logic [NEV-1:0] v);
    logic [NEV-1:0] r;
    r = '0;
    for (int i = NEV - 1; i >= 0; i--) begin
      if (v[i]) r = NEV'(1) << i;
    end
    return r;
  endfunction

  function automatic logic entry_allowed(input pstate_e s);
    return (s == PS_RUN) || (s == PS_HALT);
  endfunction

  function automatic logic sleep_legal(input pstate_e s);
    return (s == PS_GRANT) || (s == PS_SLEEP);
  endfunction

endpackage

// File: rtl/pwr_entry_timer.sv
module pwr_entry_timer
  import pwr_pkg::*;
#(
  parameter int ENTRY_CLKS = 20
) (
  input  logic    clk,
  input  logic    arst_n,
  input  pstate_e state_q,
  input  logic    state_chg,
  input  logic    stpclk_n,
  input  logic    ack_done_i,
  output logic    ack_req,
  output logic    entry_go
);

  localparam int CW = $clog2(ENTRY_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(ENTRY_CLKS - 1);

  entry_ph_e     ph_q;
  logic [CW-1:0] cnt_q;
  logic          active;

  assign active = entry_allowed(state_q);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ph_q  <= EQ_IDLE;
      cnt_q <= '0;
    end else if (state_chg || !active || stpclk_n) begin
      ph_q  <= EQ_IDLE;
      cnt_q <= '0;
    end else begin
      case (ph_q)
        EQ_IDLE: ph_q <= EQ_REQ;
        EQ_REQ: begin
          if (ack_done_i) begin
            ph_q  <= EQ_WAIT;
            cnt_q <= '0;
          end
        end
        EQ_WAIT: begin
          if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
        end
        default: ph_q <= EQ_IDLE;
      endcase
    end
  end

  assign ack_req  = (ph_q == EQ_REQ);
  assign entry_go = active && (ph_q == EQ_WAIT) && (cnt_q == LAST) && !stpclk_n;

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_pkg::*;
(
  input  logic    clk,
  input  logic    arst_n,
  input  logic    stpclk_n,
  input  logic    slp_n,
  input  logic    halt_n,
  input  logic    cpu_rst_n,
  input  logic    snoop_i,
  input  logic    bus_int_i,
  input  logic    snoop_done_i,
  input  logic    entry_go,
  output pstate_e state_q,
  output logic    state_chg,
  output logic    sleep_exit,
  output logic    rst_fall,
  output logic    core_init_o
);

  pstate_e state_d;
  logic    from_halt_q, from_halt_d;
  logic    ret_grant_q, ret_grant_d;
  logic    via_int_q, via_int_d;
  logic    rst_prev_q;
  logic    wake;

  assign rst_fall   = rst_prev_q & ~cpu_rst_n;
  assign wake       = snoop_i | bus_int_i;
  assign sleep_exit = (state_q == PS_SLEEP) && slp_n;
  assign state_chg  = (state_d != state_q);

  always_comb begin
    state_d     = state_q;
    from_halt_d = from_halt_q;
    ret_grant_d = ret_grant_q;
    via_int_d   = via_int_q;
    case (state_q)
      PS_RUN: begin
        if (rst_fall) state_d = PS_RUN;
        else if (entry_go) begin
          state_d     = PS_GRANT;
          from_halt_d = 1'b0;
        end else if (!halt_n) state_d = PS_HALT;
      end
      PS_HALT: begin
        if (rst_fall) state_d = PS_RUN;
        else if (entry_go) begin
          state_d     = PS_GRANT;
          from_halt_d = 1'b1;
        end else if (wake) begin
          state_d     = PS_SNOOP;
          ret_grant_d = 1'b0;
          via_int_d   = ~snoop_i;
        end else if (halt_n) state_d = PS_RUN;
      end
      PS_GRANT: begin
        if (rst_fall) from_halt_d = 1'b0;
        else if (stpclk_n) state_d = from_halt_q ? PS_HALT : PS_RUN;
        else if (!slp_n) state_d = PS_SLEEP;
        else if (wake) begin
          state_d     = PS_SNOOP;
          ret_grant_d = 1'b1;
          via_int_d   = ~snoop_i;
        end
      end
      PS_SNOOP: begin
        if (snoop_done_i || via_int_q) state_d = ret_grant_q ? PS_GRANT : PS_HALT;
      end
      PS_SLEEP: begin
        if (slp_n) state_d = PS_GRANT;
      end
      default: state_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q     <= PS_RUN;
      from_halt_q <= 1'b0;
      ret_grant_q <= 1'b0;
      via_int_q   <= 1'b0;
      rst_prev_q  <= 1'b1;
      core_init_o <= 1'b0;
    end else begin
      state_q     <= state_d;
      from_halt_q <= from_halt_d;
      ret_grant_q <= ret_grant_d;
      via_int_q   <= via_int_d;
      rst_prev_q  <= cpu_rst_n;
      core_init_o <= rst_fall;
    end
  end

endmodule

// File: rtl/pwr_err_monitor.sv
module pwr_err_monitor
  import pwr_pkg::*;
#(
  parameter int EXIT_CLKS = 10
) (
  input  logic    clk,
  input  logic    arst_n,
  input  pstate_e state_q,
  input  logic    state_chg,
  input  logic    sleep_exit,
  input  logic    stpclk_n,
  input  logic    slp_n,
  output logic    guard_open,
  output logic    proto_err,
  output logic    slp_err
);

  localparam int CW = $clog2(EXIT_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(EXIT_CLKS - 1);

  logic [CW-1:0] cnt_q;
  logic          violation;
  logic          bad_sleep;

  assign guard_open = (cnt_q != LAST);
  assign violation  = ((state_q == PS_SLEEP) && slp_n && stpclk_n) ||
                      ((state_q == PS_GRANT) && stpclk_n && guard_open);
  assign bad_sleep  = !slp_n && !sleep_legal(state_q);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q     <= LAST;
      proto_err <= 1'b0;
      slp_err   <= 1'b0;
    end else begin
      if (sleep_exit) cnt_q <= '0;
      else if (state_chg) cnt_q <= LAST;
      else if (guard_open) cnt_q <= cnt_q + 1'b1;
      if (violation) proto_err <= 1'b1;
      if (bad_sleep) slp_err <= 1'b1;
    end
  end

endmodule

// File: rtl/pwr_event_latch.sv
module pwr_event_latch
  import pwr_pkg::*;
(
  input  logic           clk,
  input  logic           arst_n,
  input  pstate_e        state_q,
  input  logic [NEV-1:0] ev_in,
  input  logic           clear,
  input  logic           intr_en_i,
  output logic [NEV-1:0] pending,
  output logic [NEV-1:0] replay
);

  logic [NEV-1:0] eligible;
  logic [NEV-1:0] grant;

  // the last event (bus interrupt) obeys the core mask
  assign eligible = pending & {intr_en_i, {(NEV-1){1'b1}}};
  assign grant    = pick_first(eligible);
  assign replay   = (state_q == PS_RUN) ? grant : '0;

  for (genvar i = 0; i < NEV; i++) begin : g_flag
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) pending[i] <= 1'b0;
      else if (clear) pending[i] <= 1'b0;
      else if (ev_in[i] && (state_q != PS_SLEEP)) pending[i] <= 1'b1;
      else if (replay[i]) pending[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_pkg::*;
#(
  parameter int ENTRY_CLKS = 20,
  parameter int EXIT_CLKS  = 10
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       stpclk_n,
  input  logic       slp_n,
  input  logic       cpu_rst_n,
  input  logic       halt_n,
  input  logic       snoop_i,
  input  logic       bus_int_i,
  input  logic       snoop_done_i,
  input  logic       ack_done_i,
  input  logic       smi_i,
  input  logic       init_i,
  input  logic [1:0] lint_i,
  input  logic       intr_en_i,
  output logic [2:0] state_o,
  output logic       core_clk_en_o,
  output logic       ack_req_o,
  output logic       pbe_o,
  output logic       core_init_o,
  output logic [4:0] replay_o,
  output logic       proto_err_o,
  output logic       slp_err_o
);

  pstate_e        state_q;
  logic           state_chg;
  logic           sleep_exit;
  logic           rst_fall;
  logic           entry_go;
  logic           guard_open;
  logic [NEV-1:0] pending;
  logic [NEV-1:0] ev_vec;

  assign ev_vec = {bus_int_i, lint_i[1], lint_i[0], smi_i, init_i};

  pwr_seq_fsm u_fsm (
    .clk(clk), .arst_n(arst_n), .stpclk_n(stpclk_n), .slp_n(slp_n),
    .halt_n(halt_n), .cpu_rst_n(cpu_rst_n), .snoop_i(snoop_i),
    .bus_int_i(bus_int_i), .snoop_done_i(snoop_done_i), .entry_go(entry_go),
    .state_q(state_q), .state_chg(state_chg), .sleep_exit(sleep_exit),
    .rst_fall(rst_fall), .core_init_o(core_init_o)
  );

  pwr_entry_timer #(.ENTRY_CLKS(ENTRY_CLKS)) u_entry (
    .clk(clk), .arst_n(arst_n), .state_q(state_q), .state_chg(state_chg),
    .stpclk_n(stpclk_n), .ack_done_i(ack_done_i), .ack_req(ack_req_o),
    .entry_go(entry_go)
  );

  pwr_err_monitor #(.EXIT_CLKS(EXIT_CLKS)) u_err (
    .clk(clk), .arst_n(arst_n), .state_q(state_q), .state_chg(state_chg),
    .sleep_exit(sleep_exit), .stpclk_n(stpclk_n), .slp_n(slp_n),
    .guard_open(guard_open), .proto_err(proto_err_o), .slp_err(slp_err_o)
  );

  pwr_event_latch u_ev (
    .clk(clk), .arst_n(arst_n), .state_q(state_q), .ev_in(ev_vec),
    .clear(rst_fall), .intr_en_i(intr_en_i), .pending(pending),
    .replay(replay_o)
  );

  assign state_o       = state_q;
  assign core_clk_en_o = (state_q == PS_RUN);
  assign pbe_o         = (state_q == PS_GRANT) && (|pending);

endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk (
  input logic       clk,
  input logic       arst_n,
  input logic [2:0] state,
  input logic       entry_go,
  input logic       ack_req,
  input logic       clk_en,
  input logic [4:0] replay,
  input logic       proto_err,
  input logic       slp_err,
  input logic       core_init,
  input logic       pbe,
  input logic       guard_open
);

  // R3
  entry_to_grant_chk: assert property (@(posedge clk) disable iff (!arst_n)
    entry_go |=> (state == 3'd2));

  // R3
  ack_only_awake_chk: assert property (@(posedge clk) disable iff (!arst_n)
    ack_req |-> (state == 3'd0 || state == 3'd1));

  // R6
  sleep_from_grant_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(state == 3'd4) |-> ($past(state) == 3'd2));

  // R6
  clk_gated_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (state != 3'd0) |-> !clk_en);

  // R5
  snoop_return_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(state == 3'd3) |-> (state == 3'd1 || state == 3'd2));

  // R10
  replay_single_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $onehot0(replay));

  // R10
  replay_in_run_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (|replay) |-> (state == 3'd0));

  // R7
  proto_sticky_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $past(proto_err) |-> proto_err);

  // R7
  guard_idle_outside_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (state == 3'd0 && $past(state) == 3'd0) |-> !guard_open);

  // R8
  slp_sticky_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $past(slp_err) |-> slp_err);

  // R9
  init_pulse_chk: assert property (@(posedge clk) disable iff (!arst_n)
    core_init |=> !core_init);

  // R11
  pbe_grant_only_chk: assert property (@(posedge clk) disable iff (!arst_n)
    pbe |-> (state == 3'd2));

endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk u_chk (
  .clk(clk), .arst_n(arst_n), .state(state_o), .entry_go(entry_go),
  .ack_req(ack_req_o), .clk_en(core_clk_en_o), .replay(replay_o),
  .proto_err(proto_err_o), .slp_err(slp_err_o), .core_init(core_init_o),
  .pbe(pbe_o), .guard_open(guard_open)
);

// File: tb/sim_pwr_state_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_state_ctrl;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic stpclk_n = 1'b1, slp_n = 1'b1, cpu_rst_n = 1'b1, halt_n = 1'b1;
  logic snoop_i = 1'b0, bus_int_i = 1'b0, snoop_done_i = 1'b0, ack_done_i = 1'b0;
  logic smi_i = 1'b0, init_i = 1'b0, intr_en_i = 1'b0;
  logic [1:0] lint_i = 2'b00;
  logic [2:0] state_o;
  logic core_clk_en_o, ack_req_o, pbe_o, core_init_o, proto_err_o, slp_err_o;
  logic [4:0] replay_o;

  int checks = 0;
  int fails = 0;

  localparam logic [2:0] S_RUN = 3'd0, S_HALT = 3'd1, S_GRANT = 3'd2,
                         S_SNOOP = 3'd3, S_SLEEP = 3'd4;

  always #2.5 clk = ~clk;

  pwr_state_ctrl u0 (
    .clk(clk), .arst_n(arst_n), .stpclk_n(stpclk_n), .slp_n(slp_n),
    .cpu_rst_n(cpu_rst_n), .halt_n(halt_n), .snoop_i(snoop_i),
    .bus_int_i(bus_int_i), .snoop_done_i(snoop_done_i), .ack_done_i(ack_done_i),
    .smi_i(smi_i), .init_i(init_i), .lint_i(lint_i), .intr_en_i(intr_en_i),
    .state_o(state_o), .core_clk_en_o(core_clk_en_o), .ack_req_o(ack_req_o),
    .pbe_o(pbe_o), .core_init_o(core_init_o), .replay_o(replay_o),
    .proto_err_o(proto_err_o), .slp_err_o(slp_err_o)
  );

  // row: stp slp halt snp sdone bint ackd | cycles | expected state
  function automatic logic [15:0] mkv(input logic stp, input logic slp,
      input logic hlt, input logic snp, input logic sd, input logic bi,
      input logic ak, input int n, input logic [2:0] s);
    return {stp, slp, hlt, snp, sd, bi, ak, 6'(n), s};
  endfunction

  localparam int NV = 20;
  localparam logic [15:0] VEC [NV] = '{
    mkv(1,1,0,0,0,0,0, 1,3'd1),   // R2 halt
    mkv(0,1,0,0,0,0,0, 1,3'd1),   // R3 request
    mkv(0,1,0,0,0,0,1, 1,3'd1),   // R3 response done
    mkv(0,1,0,0,0,0,0,18,3'd1),
    mkv(0,1,0,0,0,0,0, 1,3'd1),   // R3 19th edge
    mkv(0,1,0,0,0,0,0, 1,3'd2),   // R3 20th edge
    mkv(0,1,0,1,0,0,0, 1,3'd3),   // R5 snoop
    mkv(0,1,0,0,0,0,0, 2,3'd3),
    mkv(0,1,0,0,1,0,0, 1,3'd2),   // R5 back to grant
    mkv(1,1,0,0,0,0,0, 1,3'd1),   // R4 back to halt
    mkv(1,1,1,0,0,0,0, 1,3'd0),   // R2 wake
    mkv(0,1,1,0,0,0,0, 1,3'd0),
    mkv(0,1,1,0,0,0,1, 1,3'd0),
    mkv(0,1,1,0,0,0,0,19,3'd0),
    mkv(0,1,1,0,0,0,0, 1,3'd2),
    mkv(0,0,1,0,0,0,0, 1,3'd4),   // R6 sleep
    mkv(0,0,1,0,0,0,0, 2,3'd4),
    mkv(0,1,1,0,0,0,0, 1,3'd2),   // R6 exit sleep
    mkv(0,1,1,0,0,0,0, 9,3'd2),
    mkv(1,1,1,0,0,0,0, 1,3'd0)    // R7 legal rise on 10th edge, R4 to run
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic enter_grant();
    stpclk_n = 1'b0;
    step(1);
    ack_done_i = 1'b1;
    step(1);
    ack_done_i = 1'b0;
    step(20);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    step(3);
    arst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 state", 8'(state_o), 8'(S_RUN));
    chk("R1 clk_en", 8'(core_clk_en_o), 8'd1);
    chk("R1 quiet outputs", {ack_req_o, pbe_o, core_init_o, proto_err_o, slp_err_o, 3'b0}, 8'd0);
    chk("R1 replay", 8'(replay_o), 8'd0);

    for (int i = 0; i < NV; i++) begin
      {stpclk_n, slp_n, halt_n, snoop_i, snoop_done_i, bus_int_i, ack_done_i} = VEC[i][15:9];
      step(int'(VEC[i][8:3]));
      chk($sformatf("R3/R4/R5/R6 row %0d state", i), 8'(state_o), 8'(VEC[i][2:0]));
    end
    chk("R7 no violation at 10th edge", 8'(proto_err_o), 8'd0);
    chk("R8 no sleep error yet", 8'(slp_err_o), 8'd0);

    // R3 abort: stop-clock withdrawn mid-count
    stpclk_n = 1'b0;
    step(1);
    chk("R3 ack_req raised", 8'(ack_req_o), 8'd1);
    ack_done_i = 1'b1;
    step(1);
    ack_done_i = 1'b0;
    chk("R3 ack_req dropped after done", 8'(ack_req_o), 8'd0);
    step(5);
    stpclk_n = 1'b1;
    step(25);
    chk("R3 abort stays run", 8'(state_o), 8'(S_RUN));

    // R10 R11 event capture in grant, from run
    enter_grant();
    chk("R6 clk_en off in grant", 8'(core_clk_en_o), 8'd0);
    smi_i = 1'b1; step(1); smi_i = 1'b0; step(1);
    smi_i = 1'b1; init_i = 1'b1; lint_i = 2'b10; step(1);
    smi_i = 1'b0; init_i = 1'b0; lint_i = 2'b00;
    bus_int_i = 1'b1; step(1); bus_int_i = 1'b0;
    chk("R5 bus interrupt to snoop", 8'(state_o), 8'(S_SNOOP));
    step(1);
    chk("R5 interrupt return", 8'(state_o), 8'(S_GRANT));
    chk("R11 pbe with mask clear", 8'(pbe_o), 8'd1);
    chk("R10 no replay in grant", 8'(replay_o), 8'd0);
    stpclk_n = 1'b1; step(1);
    chk("R4 return to run", 8'(state_o), 8'(S_RUN));
    chk("R10 replay init", 8'(replay_o), 8'b00001);
    step(1);
    chk("R10 replay smi once", 8'(replay_o), 8'b00010);
    step(1);
    chk("R10 replay lint1", 8'(replay_o), 8'b01000);
    step(1);
    chk("R11 masked bus int held", 8'(replay_o), 8'd0);
    intr_en_i = 1'b1; #1;
    chk("R11 bus int after unmask", 8'(replay_o), 8'b10000);
    step(1);
    chk("R10 all replayed", 8'(replay_o), 8'd0);
    intr_en_i = 1'b0;

    // R9 core reset in grant entered from halt
    halt_n = 1'b0; step(1);
    enter_grant();
    chk("R9 grant from halt", 8'(state_o), 8'(S_GRANT));
    smi_i = 1'b1; step(1); smi_i = 1'b0;
    cpu_rst_n = 1'b0; step(1);
    chk("R9 init pulse", 8'(core_init_o), 8'd1);
    chk("R9 stays grant", 8'(state_o), 8'(S_GRANT));
    chk("R9 events cleared", 8'(pbe_o), 8'd0);
    cpu_rst_n = 1'b1; step(1);
    chk("R9 pulse ends", 8'(core_init_o), 8'd0);
    stpclk_n = 1'b1; step(1);
    chk("R9 exit to run", 8'(state_o), 8'(S_RUN));
    halt_n = 1'b1; step(1);

    // R5 snoop from halt
    halt_n = 1'b0; step(1);
    snoop_i = 1'b1; step(1); snoop_i = 1'b0;
    chk("R5 snoop from halt", 8'(state_o), 8'(S_SNOOP));
    step(3);
    chk("R5 waits for done", 8'(state_o), 8'(S_SNOOP));
    snoop_done_i = 1'b1; step(1); snoop_done_i = 1'b0;
    chk("R5 return to halt", 8'(state_o), 8'(S_HALT));
    halt_n = 1'b1; step(1);
    chk("R2 halt release", 8'(state_o), 8'(S_RUN));

    // R8 sleep in run ignored
    slp_n = 1'b0; step(1); slp_n = 1'b1;
    chk("R8 state unchanged", 8'(state_o), 8'(S_RUN));
    chk("R8 sticky flag", 8'(slp_err_o), 8'd1);

    // R7 early stop-clock rise after sleep
    enter_grant();
    slp_n = 1'b0; step(1);
    chk("R6 clk_en off in sleep", 8'(core_clk_en_o), 8'd0);
    slp_n = 1'b1; step(1);
    step(2);
    chk("R7 still clean", 8'(proto_err_o), 8'd0);
    stpclk_n = 1'b1; step(1);
    chk("R7 early rise flagged", 8'(proto_err_o), 8'd1);
    chk("R7 exit still taken", 8'(state_o), 8'(S_RUN));

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule